// File: doc/BRIEF.md
# Masked Pattern Trigger Unit

This block decides when a capture of sampled logic channels may begin. Each sample clock it registers the channel inputs. It takes the lowest four channels, gates them through a programmable enable mask and compares the result for equality with a programmable compare nibble. Both nibbles come from a single trigger byte that the host writes. The equality result is a level match signal, and the host can read it live.

A separate host-driven start level is captured into a tripped flag on each rising edge of the match. The flag is not set by the match level itself. Capture logic downstream samples only while the flag is high. A synchronous host clear drops the flag and the edge history, so the host can re-arm without a full reset.

To make a channel a don't care, clear both its mask bit and its compare bit. Any compare bit set without its mask bit gives a pattern that can never match.

Top module: `pattern_trigger`

## Requirements
- R1: After rstN is low, matchLevel and tripped are 0 and the stored trigger byte is 0x0F, a pattern that cannot match.
- R2: A cycle with cfgWrite high stores cfgByte. Bits 7:4 are the enable mask and bits 3:0 the compare value. Channel 0 uses bits 7 and 3, channel 1 bits 6 and 2, channel 2 bits 5 and 1, channel 3 bits 4 and 0.
- R3: Channels are registered once per clock. matchLevel is high in the cycle after the channels are applied exactly when the masked channels 0..3 equal the compare nibble (0xF8 matches channel 0 high with channels 1..3 low).
- R4: A channel whose mask bit and compare bit are both 0 has no effect on the match (0x88 matches whenever channel 0 is high).
- R5: A compare bit set while its mask bit is clear makes matchLevel stay 0 for every channel value.
- R6: Channels 4 to 7 never affect matchLevel.
- R7: On a rising edge of matchLevel, tripped takes the value startFlag had in that cycle, and the new value shows one cycle later.
- R8: Apart from R7 and R10, tripped holds its value. A falling match or a change of startFlag alone does not alter it.
- R9: If the match is already high when startFlag rises, tripped stays 0 until the match falls and rises again.
- R10: A cycle with hostClear high forces tripped to 0 and clears the edge history. A match that is still high in the next cycle then counts as a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostClear | input | 1 | Synchronous clear of trip flag and edge history |
| cfgWrite | input | 1 | Load strobe for the trigger byte |
| cfgByte | input | 8 | Trigger byte: mask in upper nibble, compare in lower |
| startFlag | input | 1 | Host start level captured on a match edge |
| channels | input | 8 | Sampled logic channels, synchronous to clk |
| matchLevel | output | 1 | Live pattern match level |
| tripped | output | 1 | Armed flag permitting capture |

## Verification
The bench builds the block with its default eight channels, four of which take part in triggering. This puts the reversed channel-to-bit mapping and the inert upper channels in view. Directed patterns use fully specified bytes, don't-care bytes and impossible bytes. The start level is placed before, during and after match edges, so that the capture-on-edge rule can be told apart from a simple level follower. Clears issued while a match is held expose the edge-history reset.

// File: rtl/pattern_trigger_pkg.sv
package pattern_trigger_pkg;
  typedef struct packed {
    logic loadTrig;
    logic clearEdge;
  } trigStrobes_t;
endpackage

// File: rtl/pattern_trigger_datapath.sv
module pattern_trigger_datapath
  import pattern_trigger_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int TRIG_CH  = 4,
  parameter logic [2*TRIG_CH-1:0] RESET_TRIG = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trigStrobes_t          strobes,
  input  logic [2*TRIG_CH-1:0]  cfgByte,
  input  logic [NUM_CH-1:0]     channels,
  output logic                  match
);
  localparam int BYTE_W = 2 * TRIG_CH;

  logic [BYTE_W-1:0]  trigReg;
  logic [NUM_CH-1:0]  chanReg;
  logic [TRIG_CH-1:0] maskNib;
  logic [TRIG_CH-1:0] cmpNib;
  logic [TRIG_CH-1:0] gated;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigReg <= RESET_TRIG;
      chanReg <= '0;
    end else begin
      chanReg <= channels;
      if (strobes.loadTrig) trigReg <= cfgByte;
    end
  end

  assign maskNib = trigReg[BYTE_W-1:TRIG_CH];
  assign cmpNib  = trigReg[TRIG_CH-1:0];

  // Channel i maps to nibble bit TRIG_CH-1-i (first channel on the MSB).
  for (genvar i = 0; i < TRIG_CH; i++) begin : g_gate
    assign gated[TRIG_CH-1-i] = chanReg[i] & maskNib[TRIG_CH-1-i];
  end

  assign match = (gated == cmpNib);

  // R5: compare bits outside the mask can never be met
  assert_impossible_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((cmpNib & ~maskNib) != '0) |-> !match);

  // R2: a load strobe makes the next compare nibble equal the written one
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTrig |=> (cmpNib == $past(cfgByte[TRIG_CH-1:0])));
endmodule

// File: rtl/pattern_trigger_control.sv
module pattern_trigger_control
  import pattern_trigger_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostClear,
  input  logic         cfgWrite,
  input  logic         startFlag,
  input  logic         matchIn,
  output trigStrobes_t strobes,
  output logic         tripped
);
  logic matchPrev;
  logic matchRise;

  assign strobes.loadTrig  = cfgWrite;
  assign strobes.clearEdge = hostClear;
  assign matchRise = matchIn & ~matchPrev;

  always_ff @(posedge clk) begin
    if (!rstN || hostClear) begin
      matchPrev <= 1'b0;
      tripped   <= 1'b0;
    end else begin
      matchPrev <= matchIn;
      if (matchRise) tripped <= startFlag;
    end
  end

  // R7: a fresh match edge captures the start level
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!hostClear && matchIn && !matchPrev) |=> (tripped == $past(startFlag)));

  // R8: without an edge or clear, the flag holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!hostClear && !(matchIn && !matchPrev)) |=> $stable(tripped));

  // R10: clear forces the flag low
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostClear |=> !tripped);

  // R9: a tripped flag can only rise with the match high
  assert_rise_needs_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripped) |-> $past(matchIn));
endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
  import pattern_trigger_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int TRIG_CH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostClear,
  input  logic                 cfgWrite,
  input  logic [2*TRIG_CH-1:0] cfgByte,
  input  logic                 startFlag,
  input  logic [NUM_CH-1:0]    channels,
  output logic                 matchLevel,
  output logic                 tripped
);
  localparam logic [2*TRIG_CH-1:0] RESET_TRIG = {{TRIG_CH{1'b0}}, {TRIG_CH{1'b1}}};

  trigStrobes_t strobes;
  logic         match;

  pattern_trigger_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .hostClear (hostClear),
    .cfgWrite  (cfgWrite),
    .startFlag (startFlag),
    .matchIn   (match),
    .strobes   (strobes),
    .tripped   (tripped)
  );

  pattern_trigger_datapath #(
    .NUM_CH     (NUM_CH),
    .TRIG_CH    (TRIG_CH),
    .RESET_TRIG (RESET_TRIG)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgByte  (cfgByte),
    .channels (channels),
    .match    (match)
  );

  assign matchLevel = match;
endmodule

// File: tb/test_pattern_trigger.sv
module test_pattern_trigger;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostClear = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [7:0] cfgByte = '0;
  logic       startFlag = 1'b0;
  logic [7:0] channels = '0;
  logic       matchLevel;
  logic       tripped;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pattern_trigger i_pattern_trigger (
    .clk(clk), .rstN(rstN), .hostClear(hostClear), .cfgWrite(cfgWrite),
    .cfgByte(cfgByte), .startFlag(startFlag), .channels(channels),
    .matchLevel(matchLevel), .tripped(tripped)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCh(input logic [7:0] v);
    channels = v;
    step();
  endtask

  task automatic loadTrig(input logic [7:0] b);
    cfgWrite = 1'b1;
    cfgByte  = b;
    step();
    cfgWrite = 1'b0;
  endtask

  task automatic clearAll();
    hostClear = 1'b1;
    step();
    hostClear = 1'b0;
  endtask

  task automatic testReset();
    setCh(8'hFF);
    check("R1 match after reset", matchLevel, 1'b0);
    check("R1 tripped after reset", tripped, 1'b0);
    setCh(8'h00);
    check("R1 reset byte never matches", matchLevel, 1'b0);
  endtask

  task automatic testFullPattern();
    startFlag = 1'b1;
    loadTrig(8'hF8);
    setCh(8'h00);
    clearAll();
    check("R3 no match with ch0 low", matchLevel, 1'b0);
    setCh(8'h01);
    check("R3 R2 match ch0 high others low", matchLevel, 1'b1);
    step();
    check("R7 trip on rising match", tripped, 1'b1);
    setCh(8'h03);
    check("R3 ch1 high breaks match", matchLevel, 1'b0);
    check("R8 trip holds on falling match", tripped, 1'b1);
    setCh(8'hF1);
    check("R6 upper channels ignored", matchLevel, 1'b1);
  endtask

  task automatic testDontCare();
    loadTrig(8'h88);
    setCh(8'h0F);
    check("R4 0x88 matches ch0 high others high", matchLevel, 1'b1);
    setCh(8'h05);
    check("R4 0x88 matches ch0 high mixed", matchLevel, 1'b1);
    setCh(8'h0E);
    check("R4 0x88 no match ch0 low", matchLevel, 1'b0);
    loadTrig(8'h11);
    setCh(8'h08);
    check("R2 channel 3 on bits 4 and 0", matchLevel, 1'b1);
  endtask

  task automatic testImpossible();
    loadTrig(8'h0F);
    setCh(8'hFF);
    check("R5 compare without mask all ones", matchLevel, 1'b0);
    loadTrig(8'h84);
    setCh(8'h03);
    check("R5 compare bit outside mask", matchLevel, 1'b0);
  endtask

  task automatic testPresentAtArm();
    startFlag = 1'b0;
    loadTrig(8'h88);
    setCh(8'h00);
    clearAll();
    setCh(8'h01);
    step();
    check("R7 start low captured as zero", tripped, 1'b0);
    startFlag = 1'b1;
    step();
    step();
    check("R9 held match does not trip", tripped, 1'b0);
    setCh(8'h00);
    step();
    check("R9 still idle after fall", tripped, 1'b0);
    setCh(8'h01);
    step();
    check("R9 trips on new edge", tripped, 1'b1);
    startFlag = 1'b0;
    step();
    step();
    check("R8 start change alone ignored", tripped, 1'b1);
  endtask

  task automatic testClear();
    startFlag = 1'b1;
    loadTrig(8'h88);
    setCh(8'h01);
    step();
    hostClear = 1'b1;
    step();
    hostClear = 1'b0;
    check("R10 clear drops trip", tripped, 1'b0);
    step();
    check("R10 held match counts as new edge", tripped, 1'b1);
    startFlag = 1'b0;
    step();
    check("R8 holds after edge", tripped, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullPattern();
    testDontCare();
    testImpossible();
    testPresentAtArm();
    testClear();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule